// File: doc/BRIEF.md
# Accumulator ALU Datapath

This block is the arithmetic core of an accumulator machine. A single accumulator register supplies the first ALU operand. The shared system bus, seen here as `bus_in`, always supplies the second operand. An eight-entry operation select from the controller picks add, subtract, three bitwise operations, complement, or a logical shift. The ALU result can be loaded back into the accumulator, driven onto the system bus, or both in the same cycle. The accumulator can also be loaded directly from the bus.

The accumulator value has two possible destinations: the ALU's A input or the bus. When the controller routes it to the bus, the ALU sees zero on its A input for that cycle. Four condition flags (zero, carry, negative, overflow) are captured only when the accumulator takes an ALU result. The bus side is registered. `bus_oe` marks the cycles in which this block owns the bus, and `bus_out` is held at zero in all other cycles, so that the bus can be formed with a simple OR of its sources.

Top module: `acc_alu_dp`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the flags and `bus_out` to zero and drops `bus_oe`.
- R2: The accumulator changes only on a clock edge where `acc_load` is 1. In every other cycle it keeps its value, whatever `bus_in`, `alu_op` and `drive_sel` are doing.
- R3: When loading, the accumulator takes `bus_in` if `acc_sel_alu` is 0, and the ALU result if `acc_sel_alu` is 1.
- R4: The ALU computes A op B, where B is `bus_in` and A is the accumulator. The `alu_op` codes are:
  - 0: ADD
  - 1: SUB (A−B)
  - 2: AND
  - 3: OR
  - 4: XOR
  - 5: NOT A
  - 6: logical shift left of A
  - 7: logical shift right of A
  
  Shift amounts are taken from the low log2(W) bits of B. All operations are W bits wide (default 32).
- R5: `acc_flags` has the following bit layout:
  - bit 0, Z: the result is zero.
  - bit 1, C: the carry out of ADD, the borrow of SUB (set when A<B unsigned), or the last bit shifted out by a shift. C is 0 for a shift of zero and for the logic operations.
  - bit 2, N: the top bit of the result.
  - bit 3, V: signed overflow of ADD or SUB. V is 0 for all other operations.
- R6: The flags are updated only on an edge where `acc_load`=1 and `acc_sel_alu`=1. A load from the bus, or a cycle with no load, leaves them unchanged.
- R7: `drive_sel` chooses what is placed on the bus at the next edge:
  - 01: the accumulator value from before that edge.
  - 10: the ALU result of that cycle.
  
  In both cases `bus_oe` is 1 for the following cycle.
- R8: While `drive_sel`=01 the accumulator is routed to the bus and not to the ALU, so ALU input A is zero in that cycle.
- R9: For `drive_sel` 00 or 11 the block does not drive the bus: `bus_oe` is 0 and `bus_out` is 0 in the following cycle. At most one source is placed on the bus at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | W | System bus value (operand B or accumulator load data) |
| alu_op | input | 3 | Operation select |
| acc_load | input | 1 | Accumulator load enable |
| acc_sel_alu | input | 1 | Accumulator source: 0 bus, 1 ALU result |
| drive_sel | input | 2 | Bus source: 00 none, 01 accumulator, 10 ALU result, 11 none |
| bus_out | output | W | Registered bus drive value, zero when not driving |
| bus_oe | output | 1 | Bus drive enable |
| acc_flags | output | 4 | {V, N, C, Z} |

## Verification
A vector table preloads the accumulator from the bus and then applies one operation. The vectors are chosen to separate the flag rules:
- Unsigned wrap against signed overflow in ADD.
- Borrow against overflow in SUB.
- A result that is zero only through XOR.
- Shifts that drop a one against shifts by zero.

Directed sequences then tell apart the paths that share data:
- A bus load against an ALU load, checked by whether the flags move.
- Result-to-bus against a load, checked by whether the accumulator moves.
- Accumulator-to-bus in the same cycle as an ALU load, which shows that the ALU saw zero on input A.
- The two non-driving select codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_NOT = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_ACC  = 2'b01,
    DRV_RES  = 2'b10,
    DRV_RSVD = 2'b11
  } drv_sel_e;

  // bit order matches the acc_flags port: {v, n, c, z}
  typedef struct packed {
    logic v;
    logic n;
    logic c;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] y,
  output alu_flags_t   flg
);

  localparam int SW = (W > 1) ? $clog2(W) : 1;

  logic [W:0]    sum_ext;
  logic [W:0]    dif_ext;
  logic [W:0]    shl_ext;
  logic [W:0]    shr_ext;
  logic [SW-1:0] shamt;

  assign shamt   = b[SW-1:0];
  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};
  assign shl_ext = {1'b0, a} << shamt;
  assign shr_ext = {a, 1'b0} >> shamt;

  always_comb begin
    y     = '0;
    flg.c = 1'b0;
    flg.v = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADD: begin
        y     = sum_ext[W-1:0];
        flg.c = sum_ext[W];
        flg.v = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
      end
      OP_SUB: begin
        y     = dif_ext[W-1:0];
        flg.c = dif_ext[W];
        flg.v = (a[W-1] != b[W-1]) && (dif_ext[W-1] != a[W-1]);
      end
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_XOR: y = a ^ b;
      OP_NOT: y = ~a;
      OP_SHL: begin
        y     = shl_ext[W-1:0];
        flg.c = shl_ext[W];
      end
      OP_SHR: begin
        y     = shr_ext[W:1];
        flg.c = shr_ext[0];
      end
      default: y = '0;
    endcase
    flg.z = (y == '0);
    flg.n = y[W-1];
  end

endmodule

// File: rtl/acc_alu_accum.sv
module acc_alu_accum
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         sel_alu,
  input  logic [W-1:0] bus_val,
  input  logic [W-1:0] alu_val,
  input  alu_flags_t   alu_flg,
  output logic [W-1:0] acc,
  output alu_flags_t   flags
);

  logic [W-1:0] acc_next;

  // accumulator input multiplexer
  assign acc_next = sel_alu ? alu_val : bus_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      flags <= '0;
    end else if (load) begin
      acc <= acc_next;
      if (sel_alu) flags <= alu_flg;
    end
  end

endmodule

// File: rtl/acc_alu_busdrv.sv
module acc_alu_busdrv
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_acc,
  input  logic         en_res,
  input  logic [W-1:0] acc_val,
  input  logic [W-1:0] res_val,
  output logic [W-1:0] out,
  output logic         oe
);

  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    if (en_acc)      pick = acc_val;
    else if (en_res) pick = res_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= '0;
      oe  <= 1'b0;
    end else begin
      out <= pick;
      oe  <= en_acc | en_res;
    end
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_in,
  input  logic [2:0]   alu_op,
  input  logic         acc_load,
  input  logic         acc_sel_alu,
  input  logic [1:0]   drive_sel,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [3:0]   acc_flags
);

  logic [W-1:0] acc_q;
  logic [W-1:0] alu_a;
  logic [W-1:0] alu_y;
  alu_flags_t   alu_f;
  alu_flags_t   flg_q;
  logic         drv_acc;
  logic         drv_res;

  assign drv_acc = (drv_sel_e'(drive_sel) == DRV_ACC);
  assign drv_res = (drv_sel_e'(drive_sel) == DRV_RES);

  // accumulator output demultiplexer: ALU input A or the bus
  assign alu_a = drv_acc ? '0 : acc_q;

  acc_alu_core #(.W(W)) u_core (
    .a   (alu_a),
    .b   (bus_in),
    .op  (alu_op),
    .y   (alu_y),
    .flg (alu_f)
  );

  acc_alu_accum #(.W(W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .load    (acc_load),
    .sel_alu (acc_sel_alu),
    .bus_val (bus_in),
    .alu_val (alu_y),
    .alu_flg (alu_f),
    .acc     (acc_q),
    .flags   (flg_q)
  );

  acc_alu_busdrv #(.W(W)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .en_acc  (drv_acc),
    .en_res  (drv_res),
    .acc_val (acc_q),
    .res_val (alu_y),
    .out     (bus_out),
    .oe      (bus_oe)
  );

  assign acc_flags = flg_q;

endmodule

// File: rtl/acc_alu_dp_chk.sv
module acc_alu_dp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] bus_in,
  input logic         acc_load,
  input logic         acc_sel_alu,
  input logic [1:0]   drive_sel,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [3:0]   acc_flags,
  input logic [W-1:0] acc_q
);

  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_load |=> acc_q == $past(acc_q));

  assert_bus_load_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_load && !acc_sel_alu) |=> acc_q == $past(bus_in));

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(acc_load && acc_sel_alu) |=> acc_flags == $past(acc_flags));

  assert_acc_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (drive_sel == 2'b01) |=> (bus_oe && bus_out == $past(acc_q)));

  assert_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (drive_sel == 2'b00 || drive_sel == 2'b11) |=> !bus_oe);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_out == '0);

endmodule

bind acc_alu_dp acc_alu_dp_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_in      (bus_in),
  .acc_load    (acc_load),
  .acc_sel_alu (acc_sel_alu),
  .drive_sel   (drive_sel),
  .bus_out     (bus_out),
  .bus_oe      (bus_oe),
  .acc_flags   (acc_flags),
  .acc_q       (acc_q)
);

// File: tb/acc_alu_dp_test.sv
`timescale 1ns/1ps
module acc_alu_dp_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic [2:0]   alu_op = '0;
  logic         acc_load = 1'b0;
  logic         acc_sel_alu = 1'b0;
  logic [1:0]   drive_sel = 2'b00;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic [3:0]   acc_flags;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu_dp #(.W(W)) uut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .alu_op(alu_op),
    .acc_load(acc_load), .acc_sel_alu(acc_sel_alu), .drive_sel(drive_sel),
    .bus_out(bus_out), .bus_oe(bus_oe), .acc_flags(acc_flags)
  );

  // {op[3], a[32], b[32], y[32], flags{V,N,C,Z}[4]}
  localparam int NV = 13;
  localparam logic [102:0] VEC [NV] = '{
    {3'd0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008, 4'b0000},
    {3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b0011},
    {3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 4'b1100},
    {3'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 4'b0110},
    {3'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 4'b1000},
    {3'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0, 4'b0000},
    {3'd3, 32'h1234_0000, 32'h0000_5678, 32'h1234_5678, 4'b0000},
    {3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0000_0000, 4'b0001},
    {3'd5, 32'h0000_FFFF, 32'h0000_1234, 32'hFFFF_0000, 4'b0100},
    {3'd6, 32'h8000_0001, 32'h0000_0001, 32'h0000_0002, 4'b0010},
    {3'd7, 32'h0000_0003, 32'h0000_0001, 32'h0000_0001, 4'b0010},
    {3'd6, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 4'b0000},
    {3'd7, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001, 4'b0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_acc(output logic [W-1:0] v);
    acc_load  = 1'b0;
    drive_sel = 2'b01;
    tick();
    v = bus_out;
    drive_sel = 2'b00;
  endtask

  task automatic bus_load(input logic [W-1:0] v);
    acc_load = 1'b1; acc_sel_alu = 1'b0; drive_sel = 2'b00; bus_in = v;
    tick();
    acc_load = 1'b0;
  endtask

  task automatic alu_load(input logic [2:0] op, input logic [W-1:0] b);
    acc_load = 1'b1; acc_sel_alu = 1'b1; drive_sel = 2'b00; alu_op = op; bus_in = b;
    tick();
    acc_load = 1'b0;
  endtask

  initial begin
    logic [W-1:0] rd;
    tick(); tick(); tick();
    chk("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
    rst = 1'b0;
    chk("R1 flags after reset", {28'd0, acc_flags}, 32'd0);
    chk("R1 bus_out after reset", bus_out, 32'd0);
    read_acc(rd);
    chk("R1 acc after reset", rd, 32'd0);

    // R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_load(VEC[i][99:68]);
      alu_load(VEC[i][102:100], VEC[i][67:36]);
      read_acc(rd);
      chk($sformatf("R4 vec%0d result", i), rd, VEC[i][35:4]);
      chk($sformatf("R5 vec%0d flags", i), {28'd0, acc_flags}, {28'd0, VEC[i][3:0]});
    end

    // R2: no load -> accumulator held while inputs change
    acc_load = 1'b0; acc_sel_alu = 1'b1; alu_op = 3'd0; bus_in = 32'hDEAD_BEEF;
    tick(); tick();
    read_acc(rd);
    chk("R2 acc held without load", rd, 32'h0000_0001);

    // R6: bus load does not touch flags
    bus_load(32'd5);
    alu_load(3'd4, 32'd5);
    chk("R6 flags after xor zero", {28'd0, acc_flags}, 32'h1);
    bus_load(32'h8000_0000);
    chk("R6 flags held over bus load", {28'd0, acc_flags}, 32'h1);
    read_acc(rd);
    chk("R3 bus load value", rd, 32'h8000_0000);

    // R7: result to bus without load
    acc_load = 1'b0; drive_sel = 2'b10; alu_op = 3'd0; bus_in = 32'h8000_0000;
    tick();
    chk("R7 result on bus", bus_out, 32'd0);
    chk("R7 oe for result", {31'd0, bus_oe}, 32'd1);
    chk("R6 flags unchanged by drive", {28'd0, acc_flags}, 32'h1);
    drive_sel = 2'b00;
    read_acc(rd);
    chk("R2 acc unchanged by result drive", rd, 32'h8000_0000);

    // R8: acc to bus while loading ALU result -> A is zero
    drive_sel = 2'b01; acc_load = 1'b1; acc_sel_alu = 1'b1; alu_op = 3'd0; bus_in = 32'd7;
    tick();
    chk("R7 old acc on bus", bus_out, 32'h8000_0000);
    acc_load = 1'b0; drive_sel = 2'b00;
    read_acc(rd);
    chk("R8 alu A zeroed", rd, 32'd7);
    chk("R8 flags of 0+7", {28'd0, acc_flags}, 32'h0);

    // R9: no drive codes
    drive_sel = 2'b00; tick();
    chk("R9 oe low code 00", {31'd0, bus_oe}, 32'd0);
    chk("R9 out zero code 00", bus_out, 32'd0);
    drive_sel = 2'b11; tick();
    chk("R9 oe low code 11", {31'd0, bus_oe}, 32'd0);
    chk("R9 out zero code 11", bus_out, 32'd0);
    drive_sel = 2'b00;

    // R1: reset in mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 flags after second reset", {28'd0, acc_flags}, 32'd0);
    read_acc(rd);
    chk("R1 acc after second reset", rd, 32'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule